// File: doc/BRIEF.md
# Inset Picture Decimation Window

This block sits between the digitizer of a secondary video source and the field memory of an inset-picture path. It takes 6-bit luma and 4-bit chroma nibbles on the line-locked sample clock, together with the inset horizontal and vertical sync pulses. From these it finds the rectangle of active picture and shrinks that rectangle by one selectable factor, applied both across and down. The result is a stream of memory writes, each carrying one reduced pixel and its address.

The block counts lines between vertical pulses to tell a 625-line source from a 525-line one, and sets the height of the capture rectangle from that result. Horizontally each output pixel is the rounded mean of N neighbouring luma samples. The chroma nibble taken at the first sample of the group rides along with it. Vertically one line in N is kept. A factor picked by software is loaded only on a vertical pulse, so every field is built with a single factor. If vertical pulses stop arriving, the block stops writing until a new one comes.

Top module: `pip_decim_top`

## Requirements
- R1: The capture area of a line covers H_WIDTH consecutive samples. The first of them is the sample clocked H_START cycles after the cycle in which a rising hsync_i edge is sampled. The area is formed only on lines V_START up to V_START+height-1, where the rising hsync_i edges after the last vertical pulse are counted from 1. Each write carries as wr_chroma_o the chroma nibble of the first sample of its group.
- R2: On every rising vsync_i edge, std625_o takes the value 1 if at least STD_THRESH rising hsync_i edges have been counted since the previous vertical pulse, and 0 otherwise. It changes at no other time. The height is V_LINES_625 when std625_o is 1 and V_LINES_525 when it is 0.
- R3: factor_sel_i encodes the factor N as 0→2, 1→3, 2→4, 3→6. Within the capture area, line V_START and every N-th line after it are kept, and each kept line yields H_WIDTH/N writes.
- R4: wr_luma_o equals floor((sum of the N luma samples of the group + floor(N/2)) / N).
- R5: wr_en_o is a single-cycle pulse, at most one in any N cycles. It is high in the cycle after the last sample of a group is clocked in, and it is low out of reset.
- R6: The write address restarts at 0 after each vertical pulse and rises by one per write. Kept line k of a field therefore starts at k*(H_WIDTH/N).
- R7: A change of factor_sel_i during a field has no effect on that field. The value present at a vertical pulse governs the whole following field.
- R8: After reset, and after more than VS_TIMEOUT lines without a vertical pulse, sync_ok_o is 0 and no writes are issued. A rising vsync_i edge restores sync_ok_o to 1.
- R9: When a vertical pulse is sampled in the same cycle as the sample that completes a group, that write is still issued with the running address, and the first write of the new field uses address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-locked sample clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_i | input | 1 | Inset horizontal sync, active high |
| vsync_i | input | 1 | Inset vertical sync, active high |
| luma_i | input | Y_W | Digitized luma sample |
| chroma_i | input | C_W | Multiplexed chroma nibble |
| factor_sel_i | input | 2 | Reduction factor code (0:2, 1:3, 2:4, 3:6) |
| wr_en_o | output | 1 | One-cycle write strobe for the field memory |
| wr_addr_o | output | ADDR_W | Field memory write address |
| wr_luma_o | output | Y_W | Averaged luma value to store |
| wr_chroma_o | output | C_W | Chroma nibble to store |
| std625_o | output | 1 | 1 when the detected standard is 625 lines |
| sync_ok_o | output | 1 | 1 while vertical timing is valid |

## Verification
The field restart and the completion of a pixel group can land on the same clock edge. The address counter must then hand out its running value and clear itself at once, and the row and standard state must switch fields without losing the write. The bench provokes this by raising vsync_i together with the second luma sample of a kept line at factor 2. It then looks for a write at the running address holding the mean of those two samples, followed by a new field whose first write sits at address 0. Stable standard flags, single-cycle strobes and address steps are also watched on every cycle.

// File: rtl/pip_pkg.sv
package pip_pkg;

  typedef enum logic [1:0] {
    FAC_2 = 2'd0,
    FAC_3 = 2'd1,
    FAC_4 = 2'd2,
    FAC_6 = 2'd3
  } fac_e;

  function automatic logic [2:0] fac_value(input fac_e f);
    case (f)
      FAC_2:   return 3'd2;
      FAC_3:   return 3'd3;
      FAC_4:   return 3'd4;
      default: return 3'd6;
    endcase
  endfunction

endpackage

// File: rtl/pip_sync_track.sv
module pip_sync_track
  import pip_pkg::*;
#(
  parameter int H_START     = 144,
  parameter int H_WIDTH     = 576,
  parameter int V_START     = 22,
  parameter int V_LINES_625 = 252,
  parameter int V_LINES_525 = 204,
  parameter int STD_THRESH  = 300,
  parameter int VS_TIMEOUT  = 700
) (
  input  logic clk,
  input  logic rst,
  input  logic hsync_i,
  input  logic vsync_i,
  input  fac_e factor_sel,
  output logic vs_rise,
  output logic capture,
  output fac_e fac_q,
  output logic std625,
  output logic sync_ok
);

  localparam int H_END = H_START + H_WIDTH;
  localparam int HC_W  = $clog2(H_END + 1);
  localparam int V_SAT = VS_TIMEOUT + 1;
  localparam int VC_W  = $clog2(V_SAT + 1);

  logic            hs_d, vs_d, hs_rise;
  logic [HC_W-1:0] h_cnt;
  logic [VC_W-1:0] v_cnt, v_next, row_end;
  logic [2:0]      vph, fac_n;
  logic            std_q, to_q;
  logic            h_in, row_in;

  assign hs_rise = hsync_i & ~hs_d;
  assign vs_rise = vsync_i & ~vs_d;
  assign fac_n   = fac_value(fac_q);
  assign v_next  = (v_cnt == VC_W'(V_SAT)) ? v_cnt : v_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_d <= 1'b0;
      vs_d <= 1'b0;
    end else begin
      hs_d <= hsync_i;
      vs_d <= vsync_i;
    end
  end

  // sample position inside the line, parked at the end when idle
  always_ff @(posedge clk) begin
    if (rst)                           h_cnt <= HC_W'(H_END);
    else if (hs_rise)                  h_cnt <= '0;
    else if (h_cnt != HC_W'(H_END))    h_cnt <= h_cnt + 1'b1;
  end

  // line count since the last vertical pulse, and the kept-row phase
  always_ff @(posedge clk) begin
    if (rst) begin
      v_cnt <= '0;
      vph   <= '0;
    end else if (vs_rise) begin
      v_cnt <= '0;
      vph   <= '0;
    end else if (hs_rise) begin
      v_cnt <= v_next;
      if (v_next <= VC_W'(V_START))  vph <= '0;
      else if (vph == fac_n - 3'd1)  vph <= '0;
      else                           vph <= vph + 3'd1;
    end
  end

  // field-level state: standard, factor, timeout
  always_ff @(posedge clk) begin
    if (rst) begin
      std_q <= 1'b0;
      fac_q <= FAC_2;
      to_q  <= 1'b1;
    end else if (vs_rise) begin
      std_q <= (v_cnt >= VC_W'(STD_THRESH));
      fac_q <= factor_sel;
      to_q  <= 1'b0;
    end else if (hs_rise && (v_next == VC_W'(V_SAT))) begin
      to_q  <= 1'b1;
    end
  end

  assign row_end = std_q ? VC_W'(V_START + V_LINES_625) : VC_W'(V_START + V_LINES_525);
  assign row_in  = (v_cnt >= VC_W'(V_START)) && (v_cnt < row_end) && (vph == 3'd0);
  assign h_in    = (h_cnt >= HC_W'(H_START)) && (h_cnt < HC_W'(H_END));
  assign capture = row_in && h_in && !to_q;
  assign std625  = std_q;
  assign sync_ok = ~to_q;

endmodule

// File: rtl/pip_hdecim.sv
module pip_hdecim
  import pip_pkg::*;
#(
  parameter int Y_W = 6,
  parameter int C_W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           capture,
  input  fac_e           fac,
  input  logic [Y_W-1:0] luma_i,
  input  logic [C_W-1:0] chroma_i,
  output logic           emit,
  output logic           wr_en,
  output logic [Y_W-1:0] wr_y,
  output logic [C_W-1:0] wr_c
);

  localparam int S_W = Y_W + 3;

  logic [S_W-1:0] acc, sum;
  logic [2:0]     ph, fac_n;
  logic [C_W-1:0] c_hold;
  logic           last;

  function automatic logic [Y_W-1:0] round_div(input logic [S_W-1:0] s, input fac_e f);
    logic [S_W-1:0] q;
    case (f)
      FAC_2:   q = (s + S_W'(1)) >> 1;
      FAC_3:   q = (s + S_W'(1)) / S_W'(3);
      FAC_4:   q = (s + S_W'(2)) >> 2;
      default: q = (s + S_W'(3)) / S_W'(6);
    endcase
    return q[Y_W-1:0];
  endfunction

  assign fac_n = fac_value(fac);
  assign last  = (ph == fac_n - 3'd1);
  assign sum   = acc + S_W'(luma_i);
  assign emit  = capture && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= '0;
      acc    <= '0;
      c_hold <= '0;
      wr_en  <= 1'b0;
      wr_y   <= '0;
      wr_c   <= '0;
    end else begin
      wr_en <= 1'b0;
      if (capture) begin
        if (last) begin
          wr_en <= 1'b1;
          wr_y  <= round_div(sum, fac);
          wr_c  <= c_hold;
          acc   <= '0;
          ph    <= '0;
        end else begin
          acc <= sum;
          ph  <= ph + 3'd1;
          if (ph == 3'd0) c_hold <= chroma_i;
        end
      end else begin
        acc <= '0;
        ph  <= '0;
      end
    end
  end

endmodule

// File: rtl/pip_addr_gen.sv
module pip_addr_gen #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vs_rise,
  input  logic              emit,
  output logic [ADDR_W-1:0] wr_addr
);

  logic [ADDR_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      wr_addr <= '0;
    end else begin
      if (emit) wr_addr <= cnt;
      if (vs_rise)   cnt <= '0;
      else if (emit) cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pip_decim_top.sv
module pip_decim_top
  import pip_pkg::*;
#(
  parameter int Y_W         = 6,
  parameter int C_W         = 4,
  parameter int ADDR_W      = 16,
  parameter int H_START     = 144,
  parameter int H_WIDTH     = 576,
  parameter int V_START     = 22,
  parameter int V_LINES_625 = 252,
  parameter int V_LINES_525 = 204,
  parameter int STD_THRESH  = 300,
  parameter int VS_TIMEOUT  = 700
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic [Y_W-1:0]    luma_i,
  input  logic [C_W-1:0]    chroma_i,
  input  logic [1:0]        factor_sel_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [Y_W-1:0]    wr_luma_o,
  output logic [C_W-1:0]    wr_chroma_o,
  output logic              std625_o,
  output logic              sync_ok_o
);

  logic vs_rise, capture, emit;
  fac_e fac_q;

  pip_sync_track #(
    .H_START(H_START), .H_WIDTH(H_WIDTH), .V_START(V_START),
    .V_LINES_625(V_LINES_625), .V_LINES_525(V_LINES_525),
    .STD_THRESH(STD_THRESH), .VS_TIMEOUT(VS_TIMEOUT)
  ) u_sync (
    .clk(clk), .rst(rst), .hsync_i(hsync_i), .vsync_i(vsync_i),
    .factor_sel(fac_e'(factor_sel_i)), .vs_rise(vs_rise), .capture(capture),
    .fac_q(fac_q), .std625(std625_o), .sync_ok(sync_ok_o)
  );

  pip_hdecim #(.Y_W(Y_W), .C_W(C_W)) u_hdec (
    .clk(clk), .rst(rst), .capture(capture), .fac(fac_q),
    .luma_i(luma_i), .chroma_i(chroma_i), .emit(emit),
    .wr_en(wr_en_o), .wr_y(wr_luma_o), .wr_c(wr_chroma_o)
  );

  pip_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .vs_rise(vs_rise), .emit(emit), .wr_addr(wr_addr_o)
  );

endmodule

// File: rtl/pip_decim_chk.sv
module pip_decim_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              vsync_i,
  input logic              wr_en_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic              std625_o,
  input logic              sync_ok_o
);

  logic              vs_q;
  logic [ADDR_W-1:0] last_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_q      <= 1'b0;
      last_addr <= '1;
    end else begin
      vs_q <= vsync_i;
      if (wr_en_o) last_addr <= wr_addr_o;
    end
  end

  // R5: a strobe never lasts two cycles
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |=> !wr_en_o);

  // R6: a nonzero address follows the previous one by exactly one
  a_r6_addr_step: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && wr_addr_o != '0) |-> (wr_addr_o == last_addr + 1'b1));

  // R8: nothing is written while timing is invalid
  a_r8_closed_no_write: assert property (@(posedge clk) disable iff (rst)
    !sync_ok_o |-> !wr_en_o);

  // R2: the standard flag moves only on a vertical edge
  a_r2_std_hold: assert property (@(posedge clk) disable iff (rst)
    !(vsync_i && !vs_q) |=> $stable(std625_o));

endmodule

bind pip_decim_top pip_decim_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .vsync_i(vsync_i), .wr_en_o(wr_en_o),
  .wr_addr_o(wr_addr_o), .std625_o(std625_o), .sync_ok_o(sync_ok_o)
);

// File: tb/tb_pip_decim_top.sv
module tb_pip_decim_top;

  localparam int HS = 2, HW = 12, VS0 = 2, V6 = 24, V5 = 12;
  localparam int TH = 26, TO = 30, LL = 20, AW = 16;
  // {sel[15:14], alt[13:12], lines[11:6], seed[5:0]}
  localparam logic [15:0] TBL [9] = '{
    {2'd0, 2'd3, 6'd16, 6'd1}, {2'd1, 2'd0, 6'd28, 6'd2},
    {2'd2, 2'd1, 6'd28, 6'd3}, {2'd3, 2'd2, 6'd16, 6'd4},
    {2'd0, 2'd2, 6'd28, 6'd5}, {2'd2, 2'd3, 6'd28, 6'd6},
    {2'd1, 2'd0, 6'd16, 6'd7}, {2'd3, 2'd1, 6'd28, 6'd8},
    {2'd0, 2'd0, 6'd16, 6'd9}
  };

  logic clk = 1'b0;
  logic rst;
  logic hsync_i, vsync_i;
  logic [5:0] luma_i;
  logic [3:0] chroma_i;
  logic [1:0] factor_sel_i;
  logic wr_en_o, std625_o, sync_ok_o;
  logic [AW-1:0] wr_addr_o;
  logic [5:0] wr_luma_o;
  logic [3:0] wr_chroma_o;

  always #5 clk = ~clk;

  pip_decim_top #(
    .ADDR_W(AW), .H_START(HS), .H_WIDTH(HW), .V_START(VS0),
    .V_LINES_625(V6), .V_LINES_525(V5), .STD_THRESH(TH), .VS_TIMEOUT(TO)
  ) dut (
    .clk(clk), .rst(rst), .hsync_i(hsync_i), .vsync_i(vsync_i),
    .luma_i(luma_i), .chroma_i(chroma_i), .factor_sel_i(factor_sel_i),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_luma_o(wr_luma_o),
    .wr_chroma_o(wr_chroma_o), .std625_o(std625_o), .sync_ok_o(sync_ok_o)
  );

  int checks = 0, errors = 0, wr_total = 0;
  int cap_a [4096];
  int cap_y [4096];
  int cap_c [4096];
  int ex_a [256];
  int ex_y [256];
  int ex_c [256];

  always @(negedge clk) begin
    if (wr_en_o) begin
      if (wr_total < 4096) begin
        cap_a[wr_total] = int'(wr_addr_o);
        cap_y[wr_total] = int'(wr_luma_o);
        cap_c[wr_total] = int'(wr_chroma_o);
      end
      wr_total++;
    end
  end

  function automatic int fy(int p, int l, int s);
    return (p * 7 + l * 13 + s * 5) % 64;
  endfunction
  function automatic int fc(int p, int l, int s);
    return (p * 3 + l + s) % 16;
  endfunction
  function automatic int facn(int sel);
    case (sel)
      0: return 2;
      1: return 3;
      2: return 4;
      default: return 6;
    endcase
  endfunction

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(input bit hs, input bit vs, input int y, input int c);
    hsync_i  = hs;
    vsync_i  = vs;
    luma_i   = 6'(y);
    chroma_i = 4'(c);
    @(negedge clk);
  endtask

  task automatic send_line(input int l, input int s);
    put(1, 0, 0, 0);
    for (int p = 0; p < LL - 1; p++) put(0, 0, fy(p, l, s), fc(p, l, s));
  endtask

  task automatic pulse_vsync();
    put(0, 1, 0, 0);
    put(0, 0, 0, 0);
  endtask

  task automatic build_expect(input int n, input int lim, input int lines,
                              input int s, output int cnt);
    cnt = 0;
    for (int l = 1; l <= lines; l++) begin
      if (l >= VS0 && l < VS0 + lim && ((l - VS0) % n) == 0) begin
        for (int g = 0; g < HW / n; g++) begin
          int sum = 0;
          for (int k = 0; k < n; k++) sum += fy(HS + g * n + k, l, s);
          ex_a[cnt] = cnt;
          ex_y[cnt] = (sum + n / 2) / n;
          ex_c[cnt] = fc(HS + g * n, l, s);
          cnt++;
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    int base, prev_lines, n_exp;
    rst = 1'b1;
    hsync_i = 0; vsync_i = 0; luma_i = 0; chroma_i = 0; factor_sel_i = 0;
    @(negedge clk);
    repeat (3) @(negedge clk);
    check(wr_en_o == 1'b0, "R5 reset strobe", int'(wr_en_o), 0);
    check(sync_ok_o == 1'b0, "R8 reset sync_ok", int'(sync_ok_o), 0);
    check(std625_o == 1'b0, "R2 reset std", int'(std625_o), 0);
    check(wr_addr_o == '0, "R6 reset addr", int'(wr_addr_o), 0);
    rst = 1'b0;
    @(negedge clk);

    // R8: no writes before the first vertical pulse
    base = wr_total;
    for (int l = 1; l <= 5; l++) send_line(l, 0);
    check(wr_total == base, "R8 writes before vsync", wr_total - base, 0);
    prev_lines = 5;

    // table of fields
    for (int i = 0; i < 9; i++) begin
      int sel, alt, lines, seed, n, std_e, bad_a, bad_y, bad_c, fa, fy_i, fc_i;
      sel   = int'(TBL[i][15:14]);
      alt   = int'(TBL[i][13:12]);
      lines = int'(TBL[i][11:6]);
      seed  = int'(TBL[i][5:0]);
      n     = facn(sel);
      std_e = (prev_lines >= TH) ? 1 : 0;
      factor_sel_i = 2'(sel);
      base = wr_total;
      pulse_vsync();
      for (int l = 1; l <= lines; l++) begin
        if (l == 4) factor_sel_i = 2'(alt);  // R7: late change must not matter
        send_line(l, seed);
      end
      repeat (3) put(0, 0, 0, 0);
      check(int'(std625_o) == std_e, "R2 standard", int'(std625_o), std_e);
      build_expect(n, std_e ? V6 : V5, lines, seed, n_exp);
      check(wr_total - base == n_exp, "R3 R7 write count", wr_total - base, n_exp);
      bad_a = -1; bad_y = -1; bad_c = -1; fa = 0; fy_i = 0; fc_i = 0;
      for (int k = 0; k < n_exp && k < wr_total - base; k++) begin
        if (bad_a < 0 && cap_a[base + k] != ex_a[k]) begin bad_a = k; fa = cap_a[base + k]; end
        if (bad_y < 0 && cap_y[base + k] != ex_y[k]) begin bad_y = k; fy_i = cap_y[base + k]; end
        if (bad_c < 0 && cap_c[base + k] != ex_c[k]) begin bad_c = k; fc_i = cap_c[base + k]; end
      end
      check(bad_a < 0, "R6 address", fa, (bad_a < 0) ? 0 : ex_a[bad_a]);
      check(bad_y < 0, "R4 averaged luma", fy_i, (bad_y < 0) ? 0 : ex_y[bad_y]);
      check(bad_c < 0, "R1 chroma nibble", fc_i, (bad_c < 0) ? 0 : ex_c[bad_c]);
      prev_lines = lines;
    end

    // R9: vertical pulse on the group-completing sample
    factor_sel_i = 2'd0;
    base = wr_total;
    pulse_vsync();
    for (int l = 1; l <= 3; l++) send_line(l, 11);
    put(1, 0, 0, 0);
    for (int p = 0; p < 3; p++) put(0, 0, fy(p, 4, 11), fc(p, 4, 11));
    put(0, 1, fy(3, 4, 11), fc(3, 4, 11));
    for (int p = 4; p < LL - 1; p++) put(0, 0, fy(p, 4, 11), fc(p, 4, 11));
    for (int l = 1; l <= 3; l++) send_line(l, 11);
    repeat (3) put(0, 0, 0, 0);
    check(wr_total - base == 13, "R9 write count", wr_total - base, 13);
    check(cap_a[base + 6] == 6, "R9 colliding write addr", cap_a[base + 6], 6);
    check(cap_y[base + 6] == (fy(2, 4, 11) + fy(3, 4, 11) + 1) / 2, "R9 colliding luma",
          cap_y[base + 6], (fy(2, 4, 11) + fy(3, 4, 11) + 1) / 2);
    check(cap_a[base + 7] == 0, "R9 R6 new field addr", cap_a[base + 7], 0);
    check(std625_o == 1'b0, "R2 short field std", int'(std625_o), 0);

    // R8: vertical timeout
    base = wr_total;
    pulse_vsync();
    for (int l = 1; l <= TO; l++) send_line(l, 12);
    check(sync_ok_o == 1'b1, "R8 still valid", int'(sync_ok_o), 1);
    send_line(TO + 1, 12);
    check(sync_ok_o == 1'b0, "R8 timed out", int'(sync_ok_o), 0);
    check(wr_total - base == 36, "R8 field writes", wr_total - base, 36);
    pulse_vsync();
    check(sync_ok_o == 1'b1, "R8 restored", int'(sync_ok_o), 1);
    check(std625_o == 1'b1, "R2 saturated count", int'(std625_o), 1);

    summary();
  end

endmodule